// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one DMA channel. It copies a block of items from a source address to a destination address over a simple request/acknowledge memory master port. When a block ends, it can load a four-word descriptor from memory and go on with the next block. The chain ends at a descriptor whose next pointer is zero. Software programs the first block through a small register port and starts the channel by setting the enable bit of the configuration register. It can also stop the channel early by clearing that bit.

The register port uses a three-bit word index:

| Index | Register |
|---|---|
| 0 | source address |
| 1 | destination address |
| 2 | next-descriptor pointer |
| 3 | control word |
| 4 | configuration (bits 18:0 stored) |
| 5 | status |

Reads return data one cycle after the read strobe.

A memory access holds `m_req`, `m_we`, `m_addr`, `m_size` and `m_wdata` steady until a cycle with `m_ack` high. In that cycle `m_err` reports a bus error, and for a read `m_rdata` carries the data. Items are right-aligned in the data word, and `m_size` carries the width code. Each data block is moved in groups: all reads of a group are done before its writes. The channel signals the end of a block with a one-cycle interrupt pulse, and errors with a separate pulse.

Top module: `sg_dma_channel`

## Requirements
- R1: After reset, every register reads zero, `m_req`, `irq_tc`, `irq_err` and `ch_active` are low.
- R2: Control bits 19:18 (with bit 20 zero) select the item width: code 0, 1 or 2 means 1, 2 or 4 bytes, and `m_size` equals that code. The transfer size in control bits 11:0 counts items, not bytes. Read-data bits above the item width are ignored, and write data is zero-extended. A request holds its address and direction until acknowledged.
- R3: With control bit 26 (source) or bit 27 (destination) set, that address grows by the item size after each item. With the bit clear, the address stays fixed.
- R4: The low two bits of control bits 13:12 choose a group length of 1, 4, 8 or 16 items (codes 0 to 3). Each group issues all of its reads before its writes, and the last group of a block holds the remaining items.
- R5: At the end of a block, `irq_tc` pulses for exactly one cycle if control bit 31 and configuration bit 15 are both set, and stays low otherwise.
- R6: If the next pointer is nonzero at block end, the channel reads four words at the pointer with its low two bits forced to zero. The words load, in order, the source, destination, next pointer and control registers, and the next block runs. If the pointer is zero, the channel clears configuration bit 0 and goes inactive.
- R7: A block with transfer size zero makes no data access but still ends normally: interrupt and chaining as in R5 and R6.
- R8: If either width field (bits 20:18 or 23:21) holds a code above 2 when a block starts, the channel sets the error flag, clears configuration bit 0, makes no data access, and pulses `irq_err` if configuration bit 14 is set.
- R9: An acknowledged access with `m_err` high sets the error flag, clears configuration bit 0, stops all further accesses and pulses `irq_err` when configuration bit 14 is set.
- R10: After software clears configuration bit 0, at most one more access completes and `ch_active` then drops.
- R11: Writes to registers 0 to 3 are ignored while the channel is active. After a run, those registers read back the channel's final working values.
- R12: Status bit 0 mirrors `ch_active` and bit 1 is the error flag. Writing 1 to status bit 1 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_re | input | 1 | register read strobe |
| reg_addr | input | 3 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, valid the cycle after `reg_re` |
| m_req | output | 1 | memory access request |
| m_we | output | 1 | 1 for write, 0 for read |
| m_addr | output | 32 | byte address |
| m_size | output | 2 | item width code |
| m_wdata | output | 32 | right-aligned write data |
| m_rdata | input | 32 | read data, valid with `m_ack` |
| m_ack | input | 1 | access completes this cycle |
| m_err | input | 1 | bus error for the completing access |
| irq_tc | output | 1 | block-end pulse |
| irq_err | output | 1 | error pulse |
| ch_active | output | 1 | channel running |

## Verification
Faults in the group counters or the address steps show at once as an out-of-order or wrongly addressed access. The bench compares every acknowledged access against a behavioural list of expected accesses, so such a fault is caught in the first cycle it appears. A wrong remaining-item count or a wrong descriptor pointer shows up either as a block-end pulse at the wrong place in that list, or as a fetch from the wrong address. A stuck run state shows within a few cycles as `ch_active` failing to drop after a stop, an error or the end of a chain.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WPREP,
    ST_WR,
    ST_END,
    ST_FETCH
  } xfer_state_t;

  localparam logic [2:0] RIX_SRC  = 3'd0;
  localparam logic [2:0] RIX_DST  = 3'd1;
  localparam logic [2:0] RIX_NXT  = 3'd2;
  localparam logic [2:0] RIX_CTL  = 3'd3;
  localparam logic [2:0] RIX_CFG  = 3'd4;
  localparam logic [2:0] RIX_STAT = 3'd5;

  localparam int CFG_W = 19;

  function automatic logic [4:0] burst_items(input logic [1:0] code);
    case (code)
      2'd0:    burst_items = 5'd1;
      2'd1:    burst_items = 5'd4;
      2'd2:    burst_items = 5'd8;
      default: burst_items = 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] w);
    case (w)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic bad_width(input logic [2:0] w);
    bad_width = (w > 3'd2);
  endfunction

endpackage

// File: rtl/sgdma_item_buf.sv
module sgdma_item_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  // Registered read with no reset, so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sgdma_ch_regs.sv
module sgdma_ch_regs
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_we,
  input  logic        sw_re,
  input  logic [2:0]  sw_addr,
  input  logic [31:0] sw_wdata,
  output logic [31:0] sw_rdata,
  input  logic        active,
  input  logic        eng_src_we,
  input  logic [31:0] eng_src,
  input  logic        eng_dst_we,
  input  logic [31:0] eng_dst,
  input  logic        eng_nxt_we,
  input  logic [31:0] eng_nxt,
  input  logic        eng_ctl_we,
  input  logic [31:0] eng_ctl,
  input  logic        eng_clr_en,
  input  logic        eng_set_err,
  output logic [31:0] src_q,
  output logic [31:0] dst_q,
  output logic [31:0] nxt_q,
  output logic [31:0] ctl_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic        err_q,
  output logic        start
);

  logic sw_hit_idle;
  assign sw_hit_idle = sw_we && !active;
  assign start = sw_we && (sw_addr == RIX_CFG) && sw_wdata[0] && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      nxt_q <= '0;
      ctl_q <= '0;
      cfg_q <= '0;
      err_q <= 1'b0;
      sw_rdata <= '0;
    end else begin
      if (eng_src_we) src_q <= eng_src;
      else if (sw_hit_idle && sw_addr == RIX_SRC) src_q <= sw_wdata;
      if (eng_dst_we) dst_q <= eng_dst;
      else if (sw_hit_idle && sw_addr == RIX_DST) dst_q <= sw_wdata;
      if (eng_nxt_we) nxt_q <= eng_nxt;
      else if (sw_hit_idle && sw_addr == RIX_NXT) nxt_q <= sw_wdata;
      if (eng_ctl_we) ctl_q <= eng_ctl;
      else if (sw_hit_idle && sw_addr == RIX_CTL) ctl_q <= sw_wdata;

      if (sw_we && sw_addr == RIX_CFG) cfg_q <= sw_wdata[CFG_W-1:0];
      if (eng_clr_en) cfg_q[0] <= 1'b0;

      if (eng_set_err) err_q <= 1'b1;
      else if (sw_we && sw_addr == RIX_STAT && sw_wdata[1]) err_q <= 1'b0;

      if (sw_re) begin
        case (sw_addr)
          RIX_SRC:  sw_rdata <= src_q;
          RIX_DST:  sw_rdata <= dst_q;
          RIX_NXT:  sw_rdata <= nxt_q;
          RIX_CTL:  sw_rdata <= ctl_q;
          RIX_CFG:  sw_rdata <= {{(32-CFG_W){1'b0}}, cfg_q};
          RIX_STAT: sw_rdata <= {30'd0, err_q, active};
          default:  sw_rdata <= '0;
        endcase
      end
    end
  end

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    eng_set_err |=> err_q);

  // R10
  en_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_clr_en |=> !cfg_q[0]);

  // R11
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !eng_src_we) |=> $stable(src_q));

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  localparam int BUF_AW = $clog2(BUF_DEPTH),
  localparam int IDX_W = BUF_AW + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] src,
  input  logic [31:0] dst,
  input  logic [31:0] nxt,
  input  logic [31:0] ctl,
  input  logic        en,
  input  logic        itc_ok,
  input  logic        ie_ok,
  output logic        m_req,
  output logic        m_we,
  output logic [31:0] m_addr,
  output logic [1:0]  m_size,
  output logic [31:0] m_wdata,
  input  logic [31:0] m_rdata,
  input  logic        m_ack,
  input  logic        m_err,
  output logic        eng_src_we,
  output logic [31:0] eng_src,
  output logic        eng_dst_we,
  output logic [31:0] eng_dst,
  output logic        eng_nxt_we,
  output logic        eng_ctl_we,
  output logic        clr_en,
  output logic        set_err,
  output logic        active,
  output logic        irq_tc,
  output logic        irq_err,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [31:0]       buf_wdata,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [31:0]       buf_rdata
);

  xfer_state_t state, state_n;
  logic [11:0]      rem;
  logic [IDX_W-1:0] grp, ridx, widx;
  logic [31:0]      fptr;
  logic [1:0]       fidx;
  logic             tc_d, err_d;

  logic [31:0] step;
  logic        width_bad, acked, good, bad;
  logic [11:0] burst12;
  logic [IDX_W-1:0] grp_first, grp_again;
  logic        unused_bits;

  assign unused_bits = ^{ctl[30:28], ctl[25:24], ctl[17:14], nxt[1:0]};

  assign step      = 32'd1 << ctl[19:18];
  assign width_bad = bad_width(ctl[20:18]) || bad_width(ctl[23:21]);
  assign burst12   = {7'd0, burst_items(ctl[13:12])};
  assign grp_first = IDX_W'((burst12 < ctl[11:0]) ? burst12 : ctl[11:0]);
  assign grp_again = IDX_W'((burst12 < rem) ? burst12 : rem);

  assign active  = (state != ST_IDLE);
  assign m_req   = (state == ST_RD) || (state == ST_WR) || (state == ST_FETCH);
  assign m_we    = (state == ST_WR);
  assign m_size  = (state == ST_FETCH) ? 2'd2 : ctl[19:18];
  assign m_wdata = buf_rdata;
  assign acked   = m_req && m_ack;
  assign good    = acked && !m_err;
  assign bad     = acked && m_err;

  always_comb begin
    case (state)
      ST_RD:    m_addr = src;
      ST_WR:    m_addr = dst;
      ST_FETCH: m_addr = fptr + {28'd0, fidx, 2'b00};
      default:  m_addr = '0;
    endcase
  end

  assign eng_src   = (state == ST_FETCH) ? m_rdata : src + (ctl[26] ? step : 32'd0);
  assign eng_dst   = (state == ST_FETCH) ? m_rdata : dst + (ctl[27] ? step : 32'd0);
  assign buf_waddr = ridx[BUF_AW-1:0];
  assign buf_wdata = m_rdata & lane_mask(ctl[19:18]);
  // Look one item ahead so the registered buffer output matches widx
  assign buf_raddr = (state != ST_WR) ? '0 :
                     (good ? BUF_AW'(widx + 1'b1) : widx[BUF_AW-1:0]);

  always_comb begin
    state_n = state;
    eng_src_we = 1'b0;
    eng_dst_we = 1'b0;
    eng_nxt_we = 1'b0;
    eng_ctl_we = 1'b0;
    clr_en = 1'b0;
    set_err = 1'b0;
    tc_d = 1'b0;
    err_d = 1'b0;
    buf_we = 1'b0;
    if (bad) begin
      set_err = 1'b1;
      clr_en = 1'b1;
      err_d = ie_ok;
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) state_n = ST_CHK;
        ST_CHK: begin
          if (width_bad) begin
            set_err = 1'b1;
            clr_en = 1'b1;
            err_d = ie_ok;
            state_n = ST_IDLE;
          end else if (!en) state_n = ST_IDLE;
          else if (ctl[11:0] == 12'd0) state_n = ST_END;
          else state_n = ST_RD;
        end
        ST_RD: if (good) begin
          buf_we = 1'b1;
          eng_src_we = 1'b1;
          if (!en) state_n = ST_IDLE;
          else if (ridx + 1'b1 == grp) state_n = ST_WPREP;
        end
        ST_WPREP: state_n = ST_WR;
        ST_WR: if (good) begin
          eng_dst_we = 1'b1;
          if (!en) state_n = ST_IDLE;
          else if (widx + 1'b1 == grp) state_n = (rem == 12'd0) ? ST_END : ST_RD;
        end
        ST_END: begin
          tc_d = ctl[31] && itc_ok;
          if (nxt[31:2] == 30'd0) begin
            clr_en = 1'b1;
            state_n = ST_IDLE;
          end else if (!en) state_n = ST_IDLE;
          else state_n = ST_FETCH;
        end
        ST_FETCH: if (good) begin
          case (fidx)
            2'd0:    eng_src_we = 1'b1;
            2'd1:    eng_dst_we = 1'b1;
            2'd2:    eng_nxt_we = 1'b1;
            default: eng_ctl_we = 1'b1;
          endcase
          if (fidx == 2'd3) state_n = ST_CHK;
          else if (!en) state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      rem <= '0;
      grp <= '0;
      ridx <= '0;
      widx <= '0;
      fptr <= '0;
      fidx <= '0;
      irq_tc <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      state <= state_n;
      irq_tc <= tc_d;
      irq_err <= err_d;
      if (state == ST_CHK && state_n == ST_RD) begin
        rem <= ctl[11:0];
        grp <= grp_first;
        ridx <= '0;
      end
      if (state == ST_RD && good) begin
        ridx <= ridx + 1'b1;
        rem <= rem - 1'b1;
      end
      if (state_n == ST_WPREP) widx <= '0;
      if (state == ST_WR && good) begin
        widx <= widx + 1'b1;
        if (state_n == ST_RD) begin
          grp <= grp_again;
          ridx <= '0;
        end
      end
      if (state == ST_END && state_n == ST_FETCH) begin
        fptr <= {nxt[31:2], 2'b00};
        fidx <= '0;
      end
      if (state == ST_FETCH && good) fidx <= fidx + 1'b1;
    end
  end

  // R5
  tc_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tc |=> !irq_tc);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> (m_size != 2'd3));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ack && m_err) |=> !active);

  // R6
  fetch_align_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && state == ST_FETCH) |-> (m_addr[1:0] == 2'b00 && !m_we));

endmodule

// File: rtl/sg_dma_channel.sv
module sg_dma_channel
  import sgdma_pkg::*;
#(
  parameter int BUF_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        m_req,
  output logic        m_we,
  output logic [31:0] m_addr,
  output logic [1:0]  m_size,
  output logic [31:0] m_wdata,
  input  logic [31:0] m_rdata,
  input  logic        m_ack,
  input  logic        m_err,
  output logic        irq_tc,
  output logic        irq_err,
  output logic        ch_active
);

  localparam int BUF_AW = $clog2(BUF_DEPTH);

  logic [31:0] src_q, dst_q, nxt_q, ctl_q;
  logic [CFG_W-1:0] cfg_q;
  logic        err_q, start;
  logic        eng_src_we, eng_dst_we, eng_nxt_we, eng_ctl_we;
  logic [31:0] eng_src, eng_dst;
  logic        clr_en, set_err;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [31:0]       buf_wdata, buf_rdata;
  logic        unused_err;

  assign unused_err = err_q;

  sgdma_ch_regs u_regs (
    .clk(clk), .rst(rst),
    .sw_we(reg_we), .sw_re(reg_re), .sw_addr(reg_addr),
    .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .active(ch_active),
    .eng_src_we(eng_src_we), .eng_src(eng_src),
    .eng_dst_we(eng_dst_we), .eng_dst(eng_dst),
    .eng_nxt_we(eng_nxt_we), .eng_nxt(m_rdata),
    .eng_ctl_we(eng_ctl_we), .eng_ctl(m_rdata),
    .eng_clr_en(clr_en), .eng_set_err(set_err),
    .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q), .ctl_q(ctl_q),
    .cfg_q(cfg_q), .err_q(err_q), .start(start)
  );

  sgdma_engine #(.BUF_DEPTH(BUF_DEPTH)) u_eng (
    .clk(clk), .rst(rst), .start(start),
    .src(src_q), .dst(dst_q), .nxt(nxt_q), .ctl(ctl_q),
    .en(cfg_q[0]), .itc_ok(cfg_q[15]), .ie_ok(cfg_q[14]),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err),
    .eng_src_we(eng_src_we), .eng_src(eng_src),
    .eng_dst_we(eng_dst_we), .eng_dst(eng_dst),
    .eng_nxt_we(eng_nxt_we), .eng_ctl_we(eng_ctl_we),
    .clr_en(clr_en), .set_err(set_err), .active(ch_active),
    .irq_tc(irq_tc), .irq_err(irq_err),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  sgdma_item_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

endmodule

// File: tb/test_sg_dma_channel.sv
module test_sg_dma_channel;

  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_WR = 1, K_TC = 2, K_ER = 3;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    int          size;
    logic [31:0] data;
  } ev_t;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [1:0] m_size;
  logic [31:0] m_rdata = 0;
  logic m_ack = 0, m_err = 0;
  logic irq_tc, irq_err, ch_active;

  int tests = 0, fails = 0;
  int lat = 0, wcnt = 0, nacc = 0, nerr = 0;
  bit chk_on = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0] bmem [4096];
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_dma_channel i_sg_dma_channel (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ack(m_ack), .m_err(m_err), .irq_tc(irq_tc), .irq_err(irq_err),
    .ch_active(ch_active)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [31:0] a, input int sz);
    logic [31:0] v;
    v = {bmem[12'(a+3)], bmem[12'(a+2)], bmem[12'(a+1)], bmem[12'(a)]};
    if (sz == 0) v = v & 32'hFF;
    else if (sz == 1) v = v & 32'hFFFF;
    return v;
  endfunction

  task automatic wword(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) bmem[12'(a+k)] = v[8*k +: 8];
  endtask

  function automatic logic [31:0] mkctl(input bit tc, input bit di, input bit si,
      input logic [2:0] dw, input logic [2:0] sw, input logic [2:0] bc, input logic [11:0] n);
    return {tc, 3'b000, di, si, 2'b00, dw, sw, 3'b000, bc, n};
  endfunction

  task automatic push(input int k, input logic [31:0] a, input int sz, input logic [31:0] d);
    ev_t e;
    e.kind = k; e.addr = a; e.size = sz; e.data = d;
    q.push_back(e);
  endtask

  // Behavioural expectation of every access and interrupt in a chain
  task automatic build(input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] n0,
                       input logic [31:0] c0, input bit itc, input bit ie);
    logic [31:0] s, d, nx, c, p;
    logic [31:0] vals [16];
    int n, g, bl, sz;
    bit go;
    s = s0; d = d0; nx = n0; c = c0; go = 1;
    while (go) begin
      if (c[20:18] > 2 || c[23:21] > 2) begin
        if (ie) push(K_ER, 0, 0, 0);
        go = 0;
      end else begin
        sz = int'(c[19:18]);
        n = int'(c[11:0]);
        bl = (c[13:12] == 0) ? 1 : (c[13:12] == 1) ? 4 : (c[13:12] == 2) ? 8 : 16;
        while (n > 0) begin
          g = (n < bl) ? n : bl;
          for (int i = 0; i < g; i++) begin
            push(K_RD, s, sz, 0);
            vals[i] = mread(s, sz);
            if (c[26]) s = s + (32'd1 << sz);
          end
          for (int i = 0; i < g; i++) begin
            push(K_WR, d, sz, vals[i]);
            if (c[27]) d = d + (32'd1 << sz);
          end
          n = n - g;
        end
        if (c[31] && itc) push(K_TC, 0, 0, 0);
        if (nx[31:2] == 0) go = 0;
        else begin
          p = {nx[31:2], 2'b00};
          for (int i = 0; i < 4; i++) push(K_RD, p + 32'(4*i), 2, 0);
          s = mread(p, 2); d = mread(p + 4, 2); nx = mread(p + 8, 2); c = mread(p + 12, 2);
        end
      end
    end
  endtask

  // Memory responder and per-clock comparison against the expectation
  always @(negedge clk) begin
    if (rst) begin
      m_ack = 0; m_err = 0; wcnt = 0;
    end else begin
      if (irq_err) nerr++;
      if (chk_on && irq_tc)
        chk(q.size() > 0 && q[0].kind == K_TC, "R5 tc pulse position", 32'(irq_tc), 32'(K_TC));
      if (chk_on && irq_tc && q.size() > 0 && q[0].kind == K_TC) void'(q.pop_front());
      if (chk_on && irq_err)
        chk(q.size() > 0 && q[0].kind == K_ER, "R8 err pulse position", 32'(irq_err), 32'(K_ER));
      if (chk_on && irq_err && q.size() > 0 && q[0].kind == K_ER) void'(q.pop_front());
      if (m_req && wcnt >= lat) begin
        m_ack = 1; wcnt = 0; nacc++;
        m_err = (m_addr == err_addr);
        if (chk_on) begin
          if (q.size() == 0) chk(0, "R2 unexpected access", m_addr, 0);
          else begin
            chk(q[0].kind == (m_we ? K_WR : K_RD) && q[0].addr == m_addr && q[0].size == int'(m_size),
                m_we ? "R3 write access" : "R4 read access", m_addr, q[0].addr);
            if (m_we) chk(q[0].data == m_wdata, "R2 write data", m_wdata, q[0].data);
            void'(q.pop_front());
          end
        end
        if (m_we) begin
          if (!m_err) for (int k = 0; k < (1 << m_size); k++) bmem[12'(m_addr+k)] = m_wdata[8*k +: 8];
          m_rdata = 32'h0;
        end else
          m_rdata = mread(m_addr, int'(m_size)) |
                    ((m_size == 0) ? 32'hEEEE_EE00 : (m_size == 1) ? 32'hEEEE_0000 : 32'h0);
      end else begin
        m_ack = 0; m_err = 0;
        if (m_req) wcnt++; else wcnt = 0;
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); #1;
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    reg_re = 1; reg_addr = a;
    @(negedge clk); #1;
    reg_re = 0; v = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    int i;
    i = 0;
    while (ch_active && i < 3000) begin @(negedge clk); i++; end
    repeat (3) @(negedge clk);
    chk(!ch_active, req, 32'(ch_active), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    int n0;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      reg_rd(3'(r), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(!m_req && !irq_tc && !irq_err && !ch_active, "R1 outputs idle",
        {28'd0, m_req, irq_tc, irq_err, ch_active}, 0);

    // R4 R3 R5: word items, group of 4 then 1, both sides incrementing
    chk_on = 1; lat = 0;
    c = mkctl(1, 1, 1, 3'd2, 3'd2, 3'd1, 12'd5);
    reg_wr(3'd0, 32'h100); reg_wr(3'd1, 32'h400); reg_wr(3'd2, 0); reg_wr(3'd3, c);
    build(32'h100, 32'h400, 0, c, 1, 0);
    reg_wr(3'd4, 32'h8001);
    wait_idle("R6 single block stops");
    chk(q.size() == 0, "R4 all accesses seen", 32'(q.size()), 0);
    reg_rd(3'd0, v); chk(v == 32'h114, "R11 final source", v, 32'h114);
    reg_rd(3'd1, v); chk(v == 32'h414, "R3 final destination", v, 32'h414);
    reg_rd(3'd4, v); chk(v[0] == 0, "R6 enable cleared", v, 32'h8000);

    // R2 R3 R5: byte items, fixed destination, interrupt masked by configuration
    lat = 1;
    c = mkctl(1, 0, 1, 3'd0, 3'd0, 3'd0, 12'd3);
    reg_wr(3'd0, 32'h203); reg_wr(3'd1, 32'h480); reg_wr(3'd3, c);
    build(32'h203, 32'h480, 0, c, 0, 0);
    reg_wr(3'd4, 32'h0001);
    wait_idle("R2 byte block stops");
    chk(q.size() == 0, "R5 masked pulse absent", 32'(q.size()), 0);
    reg_rd(3'd1, v); chk(v == 32'h480, "R3 fixed destination", v, 32'h480);
    chk(bmem[12'h480] == bmem[12'h205], "R2 byte data", 32'(bmem[12'h480]), 32'(bmem[12'h205]));

    // R6 R7 R11: three-block chain, halfword middle block, empty last block
    lat = 2;
    wword(32'h800, 32'h180); wword(32'h804, 32'h600); wword(32'h808, 32'h822);
    wword(32'h80C, mkctl(0, 1, 1, 3'd1, 3'd1, 3'd2, 12'd6));
    wword(32'h820, 32'h1C0); wword(32'h824, 32'h700); wword(32'h828, 0);
    wword(32'h82C, mkctl(1, 1, 1, 3'd2, 3'd2, 3'd0, 12'd0));
    c = mkctl(1, 1, 1, 3'd2, 3'd2, 3'd0, 12'd3);
    reg_wr(3'd0, 32'h140); reg_wr(3'd1, 32'h500); reg_wr(3'd2, 32'h801); reg_wr(3'd3, c);
    build(32'h140, 32'h500, 32'h801, c, 1, 0);
    reg_wr(3'd4, 32'h8001);
    reg_wr(3'd0, 32'hDEAD_BEEF);
    wait_idle("R6 chain stops");
    chk(q.size() == 0, "R6 chain accesses seen", 32'(q.size()), 0);
    reg_rd(3'd0, v); chk(v == 32'h1C0, "R11 source from last descriptor", v, 32'h1C0);
    reg_rd(3'd2, v); chk(v == 0, "R6 final next pointer", v, 0);
    reg_rd(3'd3, v); chk(v == mkctl(1, 1, 1, 3'd2, 3'd2, 3'd0, 12'd0), "R7 final control", v,
                         mkctl(1, 1, 1, 3'd2, 3'd2, 3'd0, 12'd0));

    // R8 R12: illegal source width
    lat = 0;
    c = mkctl(1, 1, 1, 3'd2, 3'd3, 3'd0, 12'd4);
    reg_wr(3'd2, 0); reg_wr(3'd3, c);
    build(32'h1C0, 32'h700, 0, c, 1, 1);
    n0 = nacc;
    reg_wr(3'd4, 32'hC001);
    wait_idle("R8 width error stops");
    chk(q.size() == 0 && nacc == n0, "R8 no access and err pulse", 32'(nacc - n0), 0);
    reg_rd(3'd5, v); chk(v == 32'h2, "R12 error flag set", v, 32'h2);
    reg_rd(3'd4, v); chk(v[0] == 0, "R8 enable cleared", v, 32'hC000);
    reg_wr(3'd5, 32'h2);
    reg_rd(3'd5, v); chk(v == 0, "R12 error flag cleared", v, 0);

    // R9: bus error on the third read
    chk_on = 0; err_addr = 32'h208; nerr = 0;
    c = mkctl(1, 1, 1, 3'd2, 3'd2, 3'd3, 12'd8);
    reg_wr(3'd0, 32'h200); reg_wr(3'd1, 32'h600); reg_wr(3'd3, c);
    n0 = nacc;
    reg_wr(3'd4, 32'hC001);
    wait_idle("R9 bus error stops");
    chk(nacc - n0 == 3, "R9 accesses before stop", 32'(nacc - n0), 3);
    chk(nerr == 1, "R9 error pulse", 32'(nerr), 1);
    reg_rd(3'd5, v); chk(v == 32'h2, "R9 error flag", v, 32'h2);
    reg_wr(3'd5, 32'h2);
    err_addr = 32'hFFFF_FFFF;

    // R10: software stop mid-block
    lat = 1;
    c = mkctl(0, 1, 1, 3'd2, 3'd2, 3'd3, 12'd200);
    reg_wr(3'd0, 32'h000); reg_wr(3'd1, 32'h400); reg_wr(3'd3, c);
    reg_wr(3'd4, 32'h0001);
    repeat (30) @(negedge clk);
    chk(ch_active, "R10 running before stop", 32'(ch_active), 1);
    @(negedge clk); #1;
    n0 = nacc;
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 0;
    @(negedge clk); #1;
    reg_we = 0;
    repeat (10) @(negedge clk);
    chk(!ch_active && !m_req, "R10 stopped", 32'(ch_active), 0);
    chk(nacc - n0 <= 1, "R10 accesses after stop", 32'(nacc - n0), 1);
    reg_rd(3'd5, v); chk(v == 0, "R12 status idle", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule